// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by searching a hashed page table held in ordinary memory. A request carries a 32-bit effective address, an access type, the segment descriptor for that address (virtual segment identifier, a direct-store flag and a no-execute flag), the table origin and the table size mask. The walker forms a group address from a hash of the segment identifier and the page index. It reads the eight entries of that group one at a time, and then does the same for the group at the complemented hash. It returns the physical address, or reports a page fault or a direct-store segment.

When an entry matches, the walker reads the entry's second word and sets its referenced bit, plus its changed bit for a store. It writes that word back unless the access was a probe, and returns the new word on a refill strobe so that a translation cache can load it. The walker serves one request at a time. A start pulse opens a walk, busy covers the walk, and a one-cycle done pulse closes it. Every memory read stalls until the memory answers with a response-valid strobe.

Top module: `hpt_walker`

## Requirements
- R1: With the segment direct-store flag set, a started request completes with status 2 (direct-store) on done one cycle after start. It makes no memory request, whatever the access type.
- R2: An instruction fetch (access code 2) whose segment no-execute flag is set completes with status 1 (page fault) one cycle after start and makes no memory request. For the other access types the no-execute flag has no effect.
- R3: Primary hash h = VSID[18:0] XOR {000, EA[27:12]}. Entry i of a group is read at (((h AND {mask,10'h3FF}) << 6) OR (origin << 16)) + 8*i, for i = 0 to 7 in ascending order.
- R4: After eight primary misses, the walker searches the group formed in the same way from the bitwise complement of h. In that pass the compare word carries H = 1. An entry with H = 1 never matches in the primary pass.
- R5: An entry matches only when its first word equals {V=1 at bit 31, VSID at bits 30:7, H at bit 6, EA[27:22] at bits 5:0} on every bit.
- R6: On a match, the second word is read at the entry address + 4. Status becomes 0 (translated) and the physical address is {word[31:12], EA[11:0]}.
- R7: The second word is updated by setting bit 8 (referenced) for every access and also bit 7 (changed) for a store (access code 1). It is written back to entry + 4 with one write, except for a probe (access code 3), which makes no write.
- R8: When neither pass matches, the result is status 1 after exactly sixteen reads, with no write and no refill.
- R9: busy is high from the cycle after an accepted start through the done cycle, and a start while busy is ignored. done lasts one cycle. Each read holds the walk until the response-valid strobe arrives, so a walk takes reads*(2+latency)+writes+1 cycles.
- R10: On a translated result, refill pulses with done and carries the updated second word, unless update-C-hit was set with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a walk when idle |
| acc | input | 2 | Access type: 0 read, 1 store, 2 fetch, 3 probe |
| ea | input | 32 | Effective address |
| seg_vsid | input | 24 | Virtual segment identifier |
| seg_t | input | 1 | Direct-store segment flag |
| seg_n | input | 1 | No-execute segment flag |
| tbl_org | input | 16 | Table origin (address bits 31:16) |
| tbl_mask | input | 9 | Table size mask over hash bits 18:10 |
| upd_c_hit | input | 1 | Request came from a changed-bit update of a cached hit |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 translated, 1 page fault, 2 direct-store |
| pa | output | 32 | Physical address |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |
| refill | output | 1 | Refill strobe for the translation cache |
| refill_word | output | 32 | Updated second entry word |

## Verification
Segment-level outcomes (direct-store, no-execute fault) are due on the first sample after the start cycle, and the bench checks them there. A table walk finishes after each read costs two cycles plus the response latency the bench memory inserts, plus one cycle for a write-back. The bench predicts that count from the slot position, the pass and the latency, then checks it along with the exact read address sequence. Refill, status and address are sampled in the single cycle that done is high, and the following sample confirms that done has dropped.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_PROBE = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_FAULT = 2'd1,
      ST_DSEG  = 2'd2
   } stat_e;

   typedef enum logic [2:0] {
      W_IDLE, W_RQ0, W_WT0, W_RQ1, W_WT1, W_WB, W_FIN
   } wstate_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int AW     = 32,
   parameter int VSID_W = 24,
   parameter int PIDX_W = 16,
   parameter int API_W  = 6,
   parameter int HASH_W = 19,
   parameter int ORG_W  = 16,
   parameter int MASK_W = 9,
   parameter int IDX_W  = 3,
   parameter int ENT_SH = 3
) (
   input  logic [VSID_W-1:0] vsid,
   input  logic [PIDX_W-1:0] pidx,
   input  logic              sec,
   input  logic [ORG_W-1:0]  org,
   input  logic [MASK_W-1:0] mask,
   input  logic [IDX_W-1:0]  idx,
   output logic [AW-1:0]     ent_addr,
   output logic [AW-1:0]     cmp_word
);
   localparam int FIX_W  = HASH_W - MASK_W;
   localparam int GRP_SH = IDX_W + ENT_SH;
   localparam int ORG_SH = AW - ORG_W;

   if (HASH_W > VSID_W) begin : g_bad_hash
      $error("hash wider than segment identifier");
   end
   if (PIDX_W > HASH_W) begin : g_bad_pidx
      $error("page index wider than hash");
   end
   if (2 + VSID_W + API_W != AW) begin : g_bad_cmp
      $error("compare word does not fill the data width");
   end
   if (GRP_SH + HASH_W > AW) begin : g_bad_grp
      $error("group offset exceeds address width");
   end

   logic [HASH_W-1:0] h_pri;
   logic [HASH_W-1:0] h_sel;
   logic [HASH_W-1:0] h_msk;

   // low hash bits always take part, upper bits follow the size mask
   for (genvar b = 0; b < HASH_W; b++) begin : g_msk
      if (b < FIX_W) begin : g_fix
         assign h_msk[b] = 1'b1;
      end else begin : g_var
         assign h_msk[b] = mask[b-FIX_W];
      end
   end

   assign h_pri    = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
   assign h_sel    = sec ? ~h_pri : h_pri;
   assign ent_addr = (AW'(h_sel & h_msk) << GRP_SH)
                   | (AW'(org) << ORG_SH)
                   | (AW'(idx) << ENT_SH);
   assign cmp_word = {1'b1, vsid, sec, pidx[PIDX_W-1 -: API_W]};
endmodule

// File: rtl/hpt_rc_update.sv
module hpt_rc_update
   import hpt_pkg::*;
#(
   parameter int AW    = 32,
   parameter int R_BIT = 8,
   parameter int C_BIT = 7
) (
   input  logic [AW-1:0] w_in,
   input  acc_e          acc,
   output logic [AW-1:0] w_out,
   output logic          wb_en
);
   if (R_BIT >= AW || C_BIT >= AW || R_BIT == C_BIT) begin : g_bad_bits
      $error("referenced/changed bit positions invalid");
   end

   logic [AW-1:0] set_r;
   logic [AW-1:0] set_c;

   assign set_r = AW'(1) << R_BIT;
   assign set_c = (acc == ACC_WRITE) ? (AW'(1) << C_BIT) : '0;
   assign w_out = w_in | set_r | set_c;
   assign wb_en = (acc != ACC_PROBE);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int AW          = 32,
   parameter int VSID_W      = 24,
   parameter int PIDX_W      = 16,
   parameter int API_W       = 6,
   parameter int HASH_W      = 19,
   parameter int ORG_W       = 16,
   parameter int MASK_W      = 9,
   parameter int GRP_ENTRIES = 8,
   parameter int ENT_BYTES   = 8,
   parameter int PAGE_SH     = 12,
   parameter int R_BIT       = 8,
   parameter int C_BIT       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        acc,
   input  logic [AW-1:0]     ea,
   input  logic [VSID_W-1:0] seg_vsid,
   input  logic              seg_t,
   input  logic              seg_n,
   input  logic [ORG_W-1:0]  tbl_org,
   input  logic [MASK_W-1:0] tbl_mask,
   input  logic              upd_c_hit,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status,
   output logic [AW-1:0]     pa,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [AW-1:0]     mem_wdata,
   input  logic              mem_rvalid,
   input  logic [AW-1:0]     mem_rdata,
   output logic              refill,
   output logic [AW-1:0]     refill_word
);
   localparam int IDX_W  = $clog2(GRP_ENTRIES);
   localparam int ENT_SH = $clog2(ENT_BYTES);
   localparam int W1_OFS = ENT_BYTES / 2;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GRP_ENTRIES - 1);

   if ((1 << IDX_W) != GRP_ENTRIES || (1 << ENT_SH) != ENT_BYTES) begin : g_bad_pow2
      $error("group size and entry size must be powers of two");
   end
   if (PAGE_SH + PIDX_W > AW) begin : g_bad_page
      $error("page index does not fit the address");
   end

   wstate_e             state;
   acc_e                acc_q;
   logic [PIDX_W-1:0]   pidx_q;
   logic [PAGE_SH-1:0]  ofs_q;
   logic [VSID_W-1:0]   vsid_q;
   logic [ORG_W-1:0]    org_q;
   logic [MASK_W-1:0]   mask_q;
   logic                updc_q;
   logic                sec_q;
   logic [IDX_W-1:0]    idx_q;
   logic [AW-1:0]       word1_q;
   stat_e               stat_q;
   logic [AW-1:0]       pa_q;

   logic [AW-1:0]       ent_addr;
   logic [AW-1:0]       cmp_word;
   logic [AW-1:0]       w1_upd;
   logic                wb_en;

   hpt_hash #(
      .AW(AW), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .API_W(API_W),
      .HASH_W(HASH_W), .ORG_W(ORG_W), .MASK_W(MASK_W),
      .IDX_W(IDX_W), .ENT_SH(ENT_SH)
   ) u_hash (
      .vsid(vsid_q), .pidx(pidx_q), .sec(sec_q), .org(org_q),
      .mask(mask_q), .idx(idx_q), .ent_addr(ent_addr), .cmp_word(cmp_word)
   );

   hpt_rc_update #(.AW(AW), .R_BIT(R_BIT), .C_BIT(C_BIT)) u_rc (
      .w_in(mem_rdata), .acc(acc_q), .w_out(w1_upd), .wb_en(wb_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= W_IDLE;
         acc_q   <= ACC_READ;
         pidx_q  <= '0;
         ofs_q   <= '0;
         vsid_q  <= '0;
         org_q   <= '0;
         mask_q  <= '0;
         updc_q  <= 1'b0;
         sec_q   <= 1'b0;
         idx_q   <= '0;
         word1_q <= '0;
         stat_q  <= ST_OK;
         pa_q    <= '0;
      end else begin
         case (state)
            W_IDLE: if (start) begin
               acc_q   <= acc_e'(acc);
               pidx_q  <= ea[PAGE_SH +: PIDX_W];
               ofs_q   <= ea[PAGE_SH-1:0];
               vsid_q  <= seg_vsid;
               org_q   <= tbl_org;
               mask_q  <= tbl_mask;
               updc_q  <= upd_c_hit;
               sec_q   <= 1'b0;
               idx_q   <= '0;
               word1_q <= '0;
               pa_q    <= '0;
               if (seg_t) begin
                  stat_q <= ST_DSEG;
                  state  <= W_FIN;
               end else if (acc_e'(acc) == ACC_FETCH && seg_n) begin
                  stat_q <= ST_FAULT;
                  state  <= W_FIN;
               end else begin
                  stat_q <= ST_FAULT;
                  state  <= W_RQ0;
               end
            end
            W_RQ0: state <= W_WT0;
            W_WT0: if (mem_rvalid) begin
               if (mem_rdata == cmp_word) begin
                  state <= W_RQ1;
               end else if (idx_q == IDX_LAST) begin
                  idx_q <= '0;
                  if (!sec_q) begin
                     sec_q <= 1'b1;
                     state <= W_RQ0;
                  end else begin
                     stat_q <= ST_FAULT;
                     state  <= W_FIN;
                  end
               end else begin
                  idx_q <= idx_q + 1'b1;
                  state <= W_RQ0;
               end
            end
            W_RQ1: state <= W_WT1;
            W_WT1: if (mem_rvalid) begin
               word1_q <= w1_upd;
               pa_q    <= {mem_rdata[AW-1:PAGE_SH], ofs_q};
               stat_q  <= ST_OK;
               state   <= wb_en ? W_WB : W_FIN;
            end
            W_WB:    state <= W_FIN;
            W_FIN:   state <= W_IDLE;
            default: state <= W_IDLE;
         endcase
      end
   end

   assign busy        = (state != W_IDLE);
   assign done        = (state == W_FIN);
   assign status      = stat_q;
   assign pa          = pa_q;
   assign mem_req     = (state == W_RQ0) || (state == W_RQ1) || (state == W_WB);
   assign mem_we      = (state == W_WB);
   assign mem_addr    = (state == W_RQ0) ? ent_addr : (ent_addr | AW'(W1_OFS));
   assign mem_wdata   = word1_q;
   assign refill      = (state == W_FIN) && (stat_q == ST_OK) && !updc_q;
   assign refill_word = word1_q;

   AST_DSEG_NOWALK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == W_IDLE && start && seg_t) |=> (done && status == ST_DSEG)); // R1
   AST_NX_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == W_IDLE && start && !seg_t && seg_n && acc == ACC_FETCH)
      |=> (done && status == ST_FAULT)); // R2
   AST_PROBE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (acc_q != ACC_PROBE)); // R7
   AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[R_BIT]); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_REQ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R9
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == W_WT0 && !mem_rvalid) |=> (state == W_WT0 && !mem_req)); // R9
   AST_REFILL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      refill |-> (done && status == ST_OK && refill_word[R_BIT])); // R10
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
   import hpt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  acc = 2'd0;
   logic [31:0] ea = '0;
   logic [23:0] seg_vsid = '0;
   logic        seg_t = 1'b0;
   logic        seg_n = 1'b0;
   logic [15:0] tbl_org = '0;
   logic [8:0]  tbl_mask = '0;
   logic        upd_c_hit = 1'b0;
   logic        busy, done, mem_req, mem_we, refill;
   logic [1:0]  status;
   logic [31:0] pa, mem_addr, mem_wdata, refill_word;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #2 clk = ~clk;

   hpt_walker u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .acc(acc), .ea(ea),
      .seg_vsid(seg_vsid), .seg_t(seg_t), .seg_n(seg_n), .tbl_org(tbl_org),
      .tbl_mask(tbl_mask), .upd_c_hit(upd_c_hit), .busy(busy), .done(done),
      .status(status), .pa(pa), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .refill(refill), .refill_word(refill_word)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory model
   logic [31:0] pmem [logic [31:0]];
   int          lat_cfg = 0;
   int          n_rd = 0;
   int          n_wr = 0;
   logic [31:0] rd_log [0:31];
   logic [31:0] wr_addr, wr_data;
   bit          pend = 0;
   int          pend_cnt = 0;
   logic [31:0] pend_addr;

   function automatic logic [31:0] mrd(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      if (pend) begin
         if (pend_cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mrd(pend_addr);
            pend       = 0;
         end else begin
            pend_cnt--;
         end
      end
      if (mem_req && !mem_we) begin
         pend      = 1;
         pend_cnt  = lat_cfg;
         pend_addr = mem_addr;
         if (n_rd < 32) rd_log[n_rd] = mem_addr;
         n_rd++;
      end
      if (mem_req && mem_we) begin
         n_wr++;
         wr_addr = mem_addr;
         wr_data = mem_wdata;
         pmem[mem_addr] = mem_wdata;
      end
   end

   function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] e,
                                       input bit s, input logic [15:0] o, input logic [8:0] m);
      logic [18:0] h;
      h = v[18:0] ^ {3'b000, e[27:12]};
      if (s) h = ~h;
      return ({13'b0, h & {m, 10'h3FF}} << 6) | {o, 16'h0000};
   endfunction

   function automatic logic [31:0] cmpw(input logic [23:0] v, input logic [31:0] e, input bit s);
      return {1'b1, v, s, e[27:22]};
   endfunction

   logic [1:0]  g_st;
   logic [31:0] g_pa, g_rw;
   logic        g_rf;
   int          g_cyc, g_nobusy;

   task automatic walk(input logic [1:0] a, input logic [31:0] e, input logic [23:0] v,
                       input logic t, input logic n, input logic [15:0] o,
                       input logic [8:0] m, input logic uc, input bit glitch);
      n_rd = 0; n_wr = 0; wr_addr = '0; wr_data = '0; g_nobusy = 0;
      acc = a; ea = e; seg_vsid = v; seg_t = t; seg_n = n;
      tbl_org = o; tbl_mask = m; upd_c_hit = uc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      g_cyc = 1;
      while (!done && g_cyc < 400) begin
         if (!busy) g_nobusy++;
         if (glitch && g_cyc == 3) begin
            start = 1'b1; ea = e ^ 32'h0010_0000; seg_t = 1'b1;
         end else if (glitch && g_cyc == 4) begin
            start = 1'b0; seg_t = t; ea = e;
         end
         @(negedge clk);
         g_cyc++;
      end
      chk(done, "R9", "walk reached done", {31'b0, done}, 32'h1);
      g_st = status; g_pa = pa; g_rf = refill; g_rw = refill_word;
      @(negedge clk);
      chk(!done && !busy, "R9", "done one cycle then idle", {30'b0, done, busy}, 32'h0);
   endtask

   task automatic put_pte(input logic [23:0] v, input logic [31:0] e, input bit s,
                          input logic [15:0] o, input logic [8:0] m, input int slot,
                          input logic [31:0] w1);
      logic [31:0] ad;
      ad = grp(v, e, s, o, m) + 32'(slot * 8);
      pmem[ad]     = cmpw(v, e, s);
      pmem[ad + 4] = w1;
   endtask

   task automatic expect_hit(input logic [1:0] a, input logic [31:0] e, input logic [23:0] v,
                             input logic n, input logic [15:0] o, input logic [8:0] m,
                             input bit s, input int slot, input logic [19:0] rpn,
                             input logic uc, input bit glitch, input string tag);
      logic [31:0] w1, w1x, ent;
      logic [31:0] ex [0:31];
      int cnt, exp_cyc;
      bit ok;
      w1  = {rpn, 12'h012};
      w1x = w1 | 32'h100 | ((a == 2'd1) ? 32'h80 : 32'h0);
      put_pte(v, e, s, o, m, slot, w1);
      ent = grp(v, e, s, o, m) + 32'(slot * 8);
      cnt = 0;
      if (s) for (int k = 0; k < 8; k++) begin ex[cnt] = grp(v, e, 0, o, m) + 32'(k * 8); cnt++; end
      for (int k = 0; k <= slot; k++) begin ex[cnt] = grp(v, e, s, o, m) + 32'(k * 8); cnt++; end
      ex[cnt] = ent + 4; cnt++;
      walk(a, e, v, 1'b0, n, o, m, uc, glitch);
      chk(g_st == 2'd0, "R6", {tag, " status"}, {30'b0, g_st}, 32'h0);
      chk(g_pa == {rpn, e[11:0]}, "R6", {tag, " pa"}, g_pa, {rpn, e[11:0]});
      ok = (n_rd == cnt);
      for (int k = 0; k < cnt && k < 32; k++) if (rd_log[k] != ex[k]) ok = 0;
      chk(ok, s ? "R4" : "R3", {tag, " read sequence"}, 32'(n_rd), 32'(cnt));
      if (a == 2'd3) begin
         chk(n_wr == 0, "R7", {tag, " probe no write"}, 32'(n_wr), 32'h0);
      end else begin
         chk(n_wr == 1 && wr_addr == ent + 4 && wr_data == w1x, "R7",
             {tag, " write-back"}, wr_data, w1x);
      end
      if (uc) chk(!g_rf, "R10", {tag, " no refill"}, {31'b0, g_rf}, 32'h0);
      else    chk(g_rf && g_rw == w1x, "R10", {tag, " refill word"}, g_rw, w1x);
      exp_cyc = cnt * (2 + lat_cfg) + ((a == 2'd3) ? 0 : 1) + 1;
      chk(g_cyc == exp_cyc && g_nobusy == 0, "R9", {tag, " walk length"},
          32'(g_cyc), 32'(exp_cyc));
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] e;
      logic [23:0] v;
      logic [31:0] base;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req && !refill, "R9", "reset outputs",
          {28'b0, busy, done, mem_req, refill}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // direct-store segment, any access type
      for (int a = 0; a < 4; a++) begin
         pmem.delete();
         walk(2'(a), 32'h3456_7ABC, 24'h12_3456, 1'b1, 1'b1, 16'h0010, 9'h0, 1'b0, 0);
         chk(g_st == 2'd2 && g_cyc == 1, "R1", "direct-store status", {30'b0, g_st}, 32'h2);
         chk(n_rd == 0 && n_wr == 0 && !g_rf, "R1", "no memory access", 32'(n_rd + n_wr), 32'h0);
      end

      // no-execute fetch
      walk(2'd2, 32'h1111_2345, 24'h0A_BCDE, 1'b0, 1'b1, 16'h0010, 9'h0, 1'b0, 0);
      chk(g_st == 2'd1 && g_cyc == 1 && n_rd == 0, "R2", "no-execute fetch fault",
          {30'b0, g_st}, 32'h1);
      // no-execute has no effect on loads and stores
      pmem.delete();
      expect_hit(2'd0, 32'h1111_2345, 24'h0A_BCDE, 1'b1, 16'h0010, 9'h0, 0, 2, 20'hABCDE, 0, 0, "R2 nx load");
      pmem.delete();
      expect_hit(2'd1, 32'h2222_3456, 24'h0B_0001, 1'b1, 16'h0020, 9'h0, 0, 0, 20'h13579, 0, 0, "R2 nx store");

      // primary sweep over slots, access types and latency
      for (int s = 0; s < 8; s++) begin
         pmem.delete();
         lat_cfg = s % 3;
         e = {4'h5, 16'h1234 + 16'(s * 16'h0911), 12'(s * 12'h153)};
         v = 24'hA5_C000 ^ 24'(s * 24'h01_3579);
         expect_hit(2'(s % 4), e, v, 1'b0, 16'h0040, 9'h0, 0, s, 20'(32'h80000 + s * 32'h111), 0, 0, "R3 primary");
      end

      // secondary sweep with a primary decoy carrying H=1
      for (int s = 0; s < 8; s++) begin
         pmem.delete();
         lat_cfg = (s + 1) % 3;
         e = {4'h7, 16'hBEEF - 16'(s * 16'h0707), 12'hFFF - 12'(s)};
         v = 24'h3C_0F00 + 24'(s * 24'h02_4681);
         base = grp(v, e, 0, 16'h0080, 9'h0);
         pmem[base + 32'(s * 8)] = cmpw(v, e, 1);
         pmem[base + 32'(s * 8) + 4] = 32'hFFFF_F000;
         expect_hit(2'(3 - s % 4), e, v, 1'b0, 16'h0080, 9'h0, 1, s, 20'(32'h40000 + s * 32'h2222), 0, 0, "R4 secondary");
      end

      // near misses on single compare fields
      lat_cfg = 1;
      pmem.delete();
      e = 32'h0ABC_D123; v = 24'h55_AA55;
      base = grp(v, e, 0, 16'h0100, 9'h0);
      pmem[base + 8]  = cmpw(v, e, 0) & 32'h7FFF_FFFF;
      pmem[base + 16] = cmpw(v, e, 0) ^ 32'h1;
      pmem[base + 24] = cmpw(v, e, 0) ^ 32'h80;
      pmem[base + 32] = cmpw(v, e, 0) ^ 32'h20;
      expect_hit(2'd0, e, v, 1'b0, 16'h0100, 9'h0, 0, 5, 20'h0BEEF, 0, 0, "R5 near-miss");

      // mask sweep
      lat_cfg = 0;
      for (int k = 0; k < 4; k++) begin
         logic [8:0] m;
         m = (k == 0) ? 9'h000 : (k == 1) ? 9'h001 : (k == 2) ? 9'h0AA : 9'h1FF;
         pmem.delete();
         e = 32'h0FFF_F000 ^ 32'(k * 32'h0135_7000);
         v = 24'h07_FC00 ^ 24'(k * 24'h11_1111);
         expect_hit(2'd1, e, v, 1'b0, 16'h0200 | 16'(k), m, k % 2 == 1, 3 + k, 20'(32'hC0000 + k), 0, 0, "R3 mask");
      end

      // full miss
      pmem.delete();
      lat_cfg = 2;
      e = 32'h1357_9BDF; v = 24'h24_68AC;
      walk(2'd0, e, v, 1'b0, 1'b0, 16'h0300, 9'h003, 1'b0, 0);
      begin
         bit ok;
         ok = (n_rd == 16);
         for (int k = 0; k < 16; k++)
            if (rd_log[k] != grp(v, e, k >= 8, 16'h0300, 9'h003) + 32'((k % 8) * 8)) ok = 0;
         chk(g_st == 2'd1 && ok, "R8", "miss fault after sixteen reads", 32'(n_rd), 32'd16);
         chk(n_wr == 0 && !g_rf && g_cyc == 16 * 4 + 1, "R8", "miss no write or refill",
             32'(g_cyc), 32'(16 * 4 + 1));
      end

      // update-C-hit suppresses refill
      pmem.delete();
      lat_cfg = 0;
      expect_hit(2'd1, 32'h0246_8ACE, 24'h0F_0F0F, 1'b0, 16'h0400, 9'h0, 0, 1, 20'h55555, 1, 0, "R10 updc");

      // start pulse during a walk is ignored
      pmem.delete();
      lat_cfg = 1;
      expect_hit(2'd0, 32'h0864_2000, 24'h1F_E001, 1'b0, 16'h0500, 9'h0, 1, 6, 20'h2468A, 0, 1, "R9 start ignored");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule